// File: doc/BRIEF.md
# Three-Wire Serial Register Slave for a Gain-Programmable Monitor

This block is the control port of a light-monitor front end whose amplifier gain is set digitally. A host talks to it over three wires: a frame enable, a serial clock and one data line that both sides share. Each frame carries a direction bit, a 7-bit register address and one data byte. A write frame updates a small register file. In a read frame the host releases the data line after the address, and the slave drives the addressed byte back on it.

The three serial inputs are brought into a fast system clock domain, synchronised, and edge-detected. The shared data line is presented as an input, an output and an output enable, so a pad outside the block can form the bidirectional pin. A select input picks one of two 16-register address windows. Frames aimed at the other window are ignored.

The register file provides the following decoded outputs, all updated by writes:
- a power-on flag;
- a 2-bit amplifier range;
- a 2-bit wavelength channel select;
- the 8-bit gain code of the selected channel.

Top module: `gainmon_ser_slave`

## Requirements
- R1: A frame is 16 serial clocks while `ser_en` is high. Bit 1 is the direction (1 = read, 0 = write), bits 2 to 8 are address A6..A0, and bits 9 to 16 are data D7..D0. All fields are sent MSB first, and the slave samples `ser_din` on rising `ser_clk` edges.
- R2: In a read frame that hits the window, the slave launches D7..D0 on the falling `ser_clk` edges after clocks 8 to 15. `ser_doe` is high only during that data phase, and it goes low once `ser_en` is low.
- R3: With `win_sel` low the slave answers addresses 00h to 0Fh. With `win_sel` high it answers 10h to 1Fh. A frame to any other address writes nothing and never raises `ser_doe`.
- R4: Window offset 0 is the control register, which resets to 00h. Bits 7:6 are power, where 11 sets `pwr_on` and any other value means sleep. Bits 5:4 drive `amp_range` and bits 3:2 drive `chan_sel`. Bits 1:0 always read as 0.
- R5: Window offsets 1, 2 and 3 hold the gain codes for channels DVD, CD and BD. Each resets to 80h and reads back the last value written.
- R6: `gain_code` follows `chan_sel`: 01 selects BD (offset 3), 10 selects DVD (offset 1), 11 selects CD (offset 2), and 00 gives 00h.
- R7: Writes to window offsets 04h to 0Dh change no output and no register, and reads of those offsets return 00h.
- R8: The test offsets 0Eh and 0Fh always read 00h, and writes to them change nothing.
- R9: A frame whose enable drops before the 16th rising clock performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_sel | input | 1 | Address window select (0: 00h-0Fh, 1: 10h-1Fh) |
| ser_en | input | 1 | Frame enable, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Data line as seen at the pad input |
| ser_dout | output | 1 | Read data driven toward the pad |
| ser_doe | output | 1 | Output enable for the shared data pad |
| pwr_on | output | 1 | Power field equals 11 |
| amp_range | output | 2 | Amplifier range field (01 high, 10 middle, 11 low) |
| chan_sel | output | 2 | Channel field (01 BD, 10 DVD, 11 CD) |
| gain_code | output | 8 | Gain code of the selected channel |

## Verification
The hardest condition to reach from the ports is the boundary of the turnaround. `ser_doe` must stay low through the whole address byte, must rise only after the falling edge of clock 8, and must never rise for a read outside the window. The stimulus walks every frame one serial bit at a time. It samples enable and data just before each rising edge, so any early drive or missing drive shows in the per-frame flags. Aborted writes after 12 and 15 clocks are followed by read-backs, which show that a frame one clock short commits nothing.

// File: rtl/gainmon_ser_pkg.sv
package gainmon_ser_pkg;
   typedef enum logic [1:0] {
      CH_OFF = 2'b00,
      CH_BD  = 2'b01,
      CH_DVD = 2'b10,
      CH_CD  = 2'b11
   } chan_e;

   // Window offsets of the gain registers, in storage order.
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_DVD   = 1;
   localparam int unsigned OFS_CD    = 2;
   localparam int unsigned OFS_BD    = 3;
   localparam int unsigned NUM_GAIN  = 3;
   localparam logic [1:0]  PWR_ON    = 2'b11;
endpackage

// File: rtl/gms_sync.sv
module gms_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gms_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("gms_sync: W must be positive");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      logic [W-1:0] q_s;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_s <= '0;
            else        q_s <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_s <= '0;
            else        q_s <= g_st[s-1].q_s;
         end
      end
   end

   assign q = g_st[STAGES-1].q_s;
endmodule

// File: rtl/gms_frame.sv
module gms_frame #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int OFS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic              win_sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic [OFS_W-1:0]  reg_off,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              doe
);
   localparam int HDR_BITS   = 1 + ADDR_W;
   localparam int FRAME_BITS = HDR_BITS + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int WIN_W      = ADDR_W - OFS_W;
   localparam logic [CNT_W-1:0] CNT_HDR    = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] CNT_HDR_M1 = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_END    = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_END_M1 = CNT_W'(FRAME_BITS - 1);

   if (WIN_W < 1) begin : g_bad_win
      $error("gms_frame: ADDR_W must exceed OFS_W");
   end

   logic                sclk_d, rise, fall, rd_act;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-1:0] hdr, nxt_hdr;
   logic [DATA_W-1:0]   dsh, rd_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic w);
      return a[ADDR_W-1:OFS_W] == WIN_W'(w);
   endfunction

   assign rise    = sclk_s & ~sclk_d;
   assign fall    = ~sclk_s & sclk_d;
   assign nxt_hdr = {hdr[HDR_BITS-2:0], din_s};
   assign reg_off = hdr[OFS_W-1:0];
   assign wr_data = dsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cnt    <= '0;
         hdr    <= '0;
         dsh    <= '0;
         rd_act <= 1'b0;
         rd_q   <= '0;
         dout   <= 1'b0;
         doe    <= 1'b0;
         wr_stb <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         wr_stb <= 1'b0;
         if (!en_s) begin
            cnt    <= '0;
            rd_act <= 1'b0;
            doe    <= 1'b0;
         end else begin
            if (rise && cnt != CNT_END) begin
               cnt <= cnt + 1'b1;
               if (cnt < CNT_HDR) hdr <= nxt_hdr;
               else               dsh <= {dsh[DATA_W-2:0], din_s};
               if (cnt == CNT_HDR_M1)
                  rd_act <= nxt_hdr[HDR_BITS-1] & hit(nxt_hdr[ADDR_W-1:0], win_sel);
               if (cnt == CNT_END_M1)
                  wr_stb <= ~hdr[HDR_BITS-1] & hit(hdr[ADDR_W-1:0], win_sel);
            end
            if (fall && rd_act && cnt >= CNT_HDR && cnt != CNT_END) begin
               doe <= 1'b1;
               if (cnt == CNT_HDR) begin
                  dout <= rd_data[DATA_W-1];
                  rd_q <= rd_data << 1;
               end else begin
                  dout <= rd_q[DATA_W-1];
                  rd_q <= rd_q << 1;
               end
            end
         end
      end
   end

   // R1: the bit counter never passes the frame length
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_END);
   // R2: the pad is released one cycle after enable is seen low
   p_doe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !doe);
   // R2: drive only in the data phase
   p_doe_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      doe |-> cnt >= CNT_HDR);
   // R9: a write commits only with the full frame counted
   p_full_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> cnt == CNT_END);
endmodule

// File: rtl/gms_regs.sv
module gms_regs
   import gainmon_ser_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          OFS_W    = 4,
   parameter logic [7:0]  GAIN_RST = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  reg_off,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              pwr_on,
   output logic [1:0]        amp_range,
   output logic [1:0]        chan_sel,
   output logic [DATA_W-1:0] gain_code
);
   localparam int CTRL_LSB = 2;
   localparam int CTRL_W   = DATA_W - CTRL_LSB;

   if (DATA_W < 8) begin : g_bad_data
      $error("gms_regs: DATA_W must be at least 8");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("gms_regs: OFS_W too small for the gain offsets");
   end

   logic [CTRL_W-1:0]                  ctrl_q;
   logic [NUM_GAIN-1:0][DATA_W-1:0]    gain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         for (int i = 0; i < NUM_GAIN; i++) gain_q[i] <= DATA_W'(GAIN_RST);
      end else if (wr_en) begin
         if (reg_off == OFS_W'(OFS_CTRL)) ctrl_q <= wr_data[DATA_W-1:CTRL_LSB];
         for (int i = 0; i < NUM_GAIN; i++)
            if (reg_off == OFS_W'(i + 1)) gain_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (reg_off == OFS_W'(OFS_CTRL)) rd_data = {ctrl_q, {CTRL_LSB{1'b0}}};
      for (int i = 0; i < NUM_GAIN; i++)
         if (reg_off == OFS_W'(i + 1)) rd_data = gain_q[i];
   end

   assign pwr_on    = ctrl_q[CTRL_W-1 -: 2] == PWR_ON;
   assign amp_range = ctrl_q[CTRL_W-3 -: 2];
   assign chan_sel  = ctrl_q[CTRL_W-5 -: 2];

   always_comb begin
      unique case (chan_e'(chan_sel))
         CH_BD:   gain_code = gain_q[OFS_BD-1];
         CH_DVD:  gain_code = gain_q[OFS_DVD-1];
         CH_CD:   gain_code = gain_q[OFS_CD-1];
         default: gain_code = '0;
      endcase
   end

   // R7/R8: gain storage moves only on a write to a gain offset
   p_gain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_off >= OFS_W'(1) && reg_off <= OFS_W'(NUM_GAIN))
      |=> $stable(gain_q));
   // R4: control storage moves only on a write to offset 0
   p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_off == OFS_W'(OFS_CTRL)) |=> $stable(ctrl_q));
   // R4: low control bits always read back as zero
   p_ctrl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_off == OFS_W'(OFS_CTRL) |-> rd_data[CTRL_LSB-1:0] == '0);
endmodule

// File: rtl/gainmon_ser_slave.sv
module gainmon_ser_slave #(
   parameter int         ADDR_W      = 7,
   parameter int         DATA_W      = 8,
   parameter int         OFS_W       = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] GAIN_RST    = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_sel,
   input  logic              ser_en,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_doe,
   output logic              pwr_on,
   output logic [1:0]        amp_range,
   output logic [1:0]        chan_sel,
   output logic [DATA_W-1:0] gain_code
);
   logic [2:0]        pins_s;
   logic [OFS_W-1:0]  reg_off;
   logic              wr_stb;
   logic [DATA_W-1:0] wr_data, rd_data;

   gms_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_en, ser_clk, ser_din}), .q(pins_s)
   );

   gms_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .en_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
      .win_sel(win_sel), .rd_data(rd_data), .reg_off(reg_off),
      .wr_stb(wr_stb), .wr_data(wr_data), .dout(ser_dout), .doe(ser_doe)
   );

   gms_regs #(.DATA_W(DATA_W), .OFS_W(OFS_W), .GAIN_RST(GAIN_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .reg_off(reg_off),
      .wr_data(wr_data), .rd_data(rd_data), .pwr_on(pwr_on),
      .amp_range(amp_range), .chan_sel(chan_sel), .gain_code(gain_code)
   );
endmodule

// File: tb/gainmon_ser_slave_bench.sv
module gainmon_ser_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic win_sel = 1'b0, ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
   logic ser_dout, ser_doe, pwr_on;
   logic [1:0] amp_range, chan_sel;
   logic [7:0] gain_code;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gainmon_ser_slave u_gainmon_ser_slave (
      .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .ser_en(ser_en),
      .ser_clk(ser_clk), .ser_din(ser_din), .ser_dout(ser_dout),
      .ser_doe(ser_doe), .pwr_on(pwr_on), .amp_range(amp_range),
      .chan_sel(chan_sel), .gain_code(gain_code)
   );

   // Row: win[37] addr[36:30] wdata[29:22] rexp[21:14] rdrv[13] gexp[12:5] {pwr,range,chan}[4:0]
   localparam int NV = 13;
   localparam logic [37:0] VEC [NV] = '{
      {1'b0, 7'h01, 8'hA5, 8'hA5, 1'b1, 8'h00, 5'b0_00_00},
      {1'b0, 7'h02, 8'h3C, 8'h3C, 1'b1, 8'h00, 5'b0_00_00},
      {1'b0, 7'h03, 8'hC3, 8'hC3, 1'b1, 8'h00, 5'b0_00_00},
      {1'b0, 7'h00, 8'hFC, 8'hFC, 1'b1, 8'h3C, 5'b1_11_11},
      {1'b0, 7'h00, 8'h68, 8'h68, 1'b1, 8'hA5, 5'b0_10_10},
      {1'b0, 7'h00, 8'h37, 8'h34, 1'b1, 8'hC3, 5'b0_11_01},
      {1'b0, 7'h05, 8'hFF, 8'h00, 1'b1, 8'hC3, 5'b0_11_01},
      {1'b0, 7'h0E, 8'h55, 8'h00, 1'b1, 8'hC3, 5'b0_11_01},
      {1'b0, 7'h0F, 8'hAA, 8'h00, 1'b1, 8'hC3, 5'b0_11_01},
      {1'b0, 7'h13, 8'h11, 8'h00, 1'b0, 8'hC3, 5'b0_11_01},
      {1'b1, 7'h13, 8'h11, 8'h11, 1'b1, 8'h11, 5'b0_11_01},
      {1'b1, 7'h03, 8'h22, 8'h00, 1'b0, 8'h11, 5'b0_11_01},
      {1'b1, 7'h11, 8'h99, 8'h99, 1'b1, 8'h11, 5'b0_11_01}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic w, input logic [6:0] a);
      if (a[6:4] != {2'b00, w}) return "R3 window";
      if (a[3:0] == 4'h0) return "R1/R2/R4 ctrl read";
      if (a[3:0] <= 4'h3) return "R1/R2/R5 gain read";
      if (a[3:0] <= 4'hD) return "R7 reserved read";
      return "R8 test read";
   endfunction

   task automatic run_frame(input logic w, input logic rd, input logic [6:0] a,
                            input logic [7:0] wd, input int nclk,
                            output logic [7:0] rb, output logic drove_all,
                            output logic drove_any, output logic early_oe);
      logic [15:0] bits;
      bits = {rd, a, wd};
      rb = '0; drove_all = 1'b1; drove_any = 1'b0; early_oe = 1'b0;
      win_sel = w;
      @(negedge clk);
      ser_en = 1'b1;
      repeat (8) @(negedge clk);
      for (int b = 0; b < nclk; b++) begin
         ser_din = (rd && b >= 8) ? 1'b0 : bits[15-b];
         repeat (8) @(negedge clk);
         if (rd && b >= 8) begin
            rb = {rb[6:0], ser_dout};
            if (!ser_doe) drove_all = 1'b0;
            if (ser_doe)  drove_any = 1'b1;
         end else if (ser_doe) early_oe = 1'b1;
         ser_clk = 1'b1;
         repeat (8) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (8) @(negedge clk);
      ser_en = 1'b0;
      repeat (24) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rb;
      logic da, dy, eo;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Reset state: R4, R6, R2
      chk("R4 reset pwr/range/chan", {pwr_on, amp_range, chan_sel}, 5'b0);
      chk("R6 reset gain_code with chan 00", gain_code, 8'h00);
      chk("R2 reset doe", ser_doe, 1'b0);
      run_frame(1'b0, 1'b1, 7'h00, 8'h00, 16, rb, da, dy, eo);
      chk("R4 ctrl reset read", rb, 8'h00);
      for (int g = 1; g <= 3; g++) begin
         run_frame(1'b0, 1'b1, 7'(g), 8'h00, 16, rb, da, dy, eo);
         chk("R5 gain reset read", rb, 8'h80);
         chk("R2 drove whole data phase", da, 1'b1);
         chk("R2 no drive in address phase", eo, 1'b0);
      end

      // Table walk: write, read back, decoded outputs
      for (int i = 0; i < NV; i++) begin
         logic [37:0] v;
         v = VEC[i];
         run_frame(v[37], 1'b0, v[36:30], v[29:22], 16, rb, da, dy, eo);
         chk("R6 gain_code after write", gain_code, v[12:5]);
         chk("R4 pwr/range/chan after write", {pwr_on, amp_range, chan_sel}, v[4:0]);
         run_frame(v[37], 1'b1, v[36:30], 8'h00, 16, rb, da, dy, eo);
         if (v[13]) begin
            chk(tag_of(v[37], v[36:30]), rb, v[21:14]);
            chk("R2 drove whole data phase", da, 1'b1);
         end else begin
            chk("R3 no drive outside window", dy, 1'b0);
         end
         chk("R2 no drive in address phase", eo, 1'b0);
         chk("R2 doe low after enable drop", ser_doe, 1'b0);
      end

      // Window check: offset 03 under window 0 kept its value despite row 12
      run_frame(1'b0, 1'b1, 7'h03, 8'h00, 16, rb, da, dy, eo);
      chk("R3 out-of-window write ignored", rb, 8'h11);

      // Aborted frames: R9
      run_frame(1'b1, 1'b0, 7'h11, 8'h55, 12, rb, da, dy, eo);
      run_frame(1'b1, 1'b1, 7'h11, 8'h00, 16, rb, da, dy, eo);
      chk("R9 abort after 12 clocks", rb, 8'h99);
      run_frame(1'b1, 1'b0, 7'h11, 8'h77, 15, rb, da, dy, eo);
      run_frame(1'b1, 1'b1, 7'h11, 8'h00, 16, rb, da, dy, eo);
      chk("R9 abort after 15 clocks", rb, 8'h99);
      run_frame(1'b1, 1'b0, 7'h13, 8'h5A, 15, rb, da, dy, eo);
      chk("R9 gain_code unchanged after abort", gain_code, 8'h11);

      // R7 write to reserved offset leaves outputs alone
      run_frame(1'b1, 1'b0, 7'h18, 8'hFF, 16, rb, da, dy, eo);
      chk("R7 reserved write outputs", {pwr_on, amp_range, chan_sel, gain_code}, {5'b0_11_01, 8'h11});

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule